// File: doc/BRIEF.md
# Short Float Pack/Unpack Converter

This block converts values between 32-bit IEEE single-precision floats and a compact 16-bit float. The 16-bit form halves storage in long delay lines, such as the state of recursive filters, while keeping a floating exponent. The 16-bit word has a sign in bit 15, a 4-bit exponent field in bits 14:11 and an 11-bit mantissa field in bits 10:0.

The exponent field holds the 32-bit biased exponent minus 120. Fields 1 to 15 encode normal values 1.m × 2^(field−7). Field 0 gives gradual underflow: the value is m × 2^−17 with no hidden bit. The largest magnitude is just under 2^9, and the smallest non-zero magnitude is 2^−17.

A mode input chooses the direction for each transfer: pack (32 to 16) or unpack (16 to 32). A transfer is accepted when its valid input is high. The result and two status flags come out of one register stage one cycle later. Packing rounds to nearest-even, saturates values that are too large and flushes values that are too small.

Top module: `shortFloatConv`

## Requirements
- R1: When `inValid` is high at a clock edge, `outValid` is high after that edge. When `inValid` is low at an edge, `outValid` is low after it. Reset clears `outValid`, `outWord`, `ovfFlag` and `unfFlag`.
- R2: A cycle with `inValid` low leaves `outWord`, `ovfFlag` and `unfFlag` unchanged, whatever `inWord` and `modeUnpack` carry.
- R3: Pack (`modeUnpack`=0) of a source with biased exponent B in 121..135 gives exponent field B−120 and mantissa field equal to source fraction bits 22:12. That mantissa is rounded to nearest-even using bit 11 as the guard bit and bits 10:0 as the sticky bits. The result sits in `outWord[15:0]`, and `outWord[31:16]` is zero.
- R4: In pack mode, a rounding carry out of the 11-bit mantissa clears the mantissa and increments the exponent field.
- R5: Pack of a source with B in 1..120 gives exponent field 0 and mantissa round-nearest-even of 1.f × 2^(B−110). If that rounding reaches 2048, the result becomes exponent field 1 with mantissa 0.
- R6: In pack mode, a source with B above 135 (infinity included), or one whose rounding carries past exponent field 15, gives {sign, 15'h7FFF}. It also sets `ovfFlag`.
- R7: In pack mode, a non-zero source whose result rounds to zero, or one with B=0, gives a signed zero and sets `unfFlag`. An exact zero gives a signed zero with no flag.
- R8: Unpack (`modeUnpack`=1) of a word with exponent field e in 1..15 gives biased exponent e+120 and fraction {mantissa, 12'b0}, with the sign kept. `inWord[31:16]` is ignored.
- R9: Unpack of a word with exponent field 0 and a non-zero mantissa is renormalized. With p the position of the mantissa's top set bit, the biased exponent is p+110, and the bits below that set bit move to the top of the fraction. A zero magnitude unpacks to a signed zero.
- R10: Unpack results always have `ovfFlag` and `unfFlag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Accept a conversion this cycle |
| modeUnpack | input | 1 | 1 = 16-bit to 32-bit, 0 = 32-bit to 16-bit |
| inWord | input | 32 | Source value; unpack uses bits 15:0 |
| outValid | output | 1 | Result registered from the previous cycle |
| outWord | output | 32 | Converted value; pack result in bits 15:0 |
| ovfFlag | output | 1 | Pack saturated to the largest magnitude |
| unfFlag | output | 1 | Pack flushed a non-zero value to zero |

## Verification
Rounding and range handling can act on the same value in one cycle, and the interesting cases are where one feeds the other. A mantissa of all ones whose guard bit forces a round-up carries into the exponent. At exponent field 15 that carry must become saturation with the overflow flag. At exponent field 0 the same kind of carry must instead promote a subnormal result to the smallest normal value. Vectors are placed exactly on these seams and on the ties just below the smallest non-zero value. Each output word and flag pair is compared with values worked out by hand from the format rules. Because the vectors run back to back with alternating modes, any flag left over from a previous pack would also show up in the unpack results that follow.

// File: rtl/sfcPkg.sv
package sfcPkg;
  localparam int LONG_EXP_W        = 8;
  localparam int LONG_FRAC_W       = 23;
  localparam int SHORT_EXP_W       = 4;
  localparam int SHORT_MAN_W       = 11;
  localparam int SHORT_EXP_OFFSET  = 120;

  localparam int LONG_W            = 1 + LONG_EXP_W + LONG_FRAC_W;
  localparam int SHORT_W           = 1 + SHORT_EXP_W + SHORT_MAN_W;
  localparam int SHORT_MAG_W       = SHORT_EXP_W + SHORT_MAN_W;
  localparam int SIG_W             = LONG_FRAC_W + 1;
  localparam int FRAC_DROP         = LONG_FRAC_W - SHORT_MAN_W;
  localparam int SHORT_EXP_MAX     = (1 << SHORT_EXP_W) - 1;
  localparam int LONG_EXP_TOP      = SHORT_EXP_OFFSET + SHORT_EXP_MAX;
  localparam int DENORM_SHIFT_BASE = SHORT_EXP_OFFSET + 1 + FRAC_DROP;
  localparam int DENORM_EXP_BASE   = SHORT_EXP_OFFSET + 1 - SHORT_MAN_W;
  localparam int SHIFT_CLAMP       = SIG_W + 2;
  localparam int WIN_W             = SIG_W + SHORT_MAN_W + 1;
  localparam int SHIFT_W           = $clog2(2 * SIG_W + 2);
  localparam int LEAD_W            = $clog2(SHORT_MAN_W);
  localparam int ALIGN_SH_W        = $clog2(SIG_W);

  typedef struct packed {
    logic loadOut;
    logic selUnpack;
  } sfcStrobe_t;
endpackage

// File: rtl/sfcPackCore.sv
module sfcPackCore
  import sfcPkg::*;
(
  input  logic [LONG_W-1:0]  srcWord,
  output logic [SHORT_W-1:0] dstWord,
  output logic               ovfOut,
  output logic               unfOut
);
  logic                    sgn;
  logic [LONG_EXP_W-1:0]   bexp;
  logic [LONG_FRAC_W-1:0]  frac;
  assign {sgn, bexp, frac} = srcWord;

  logic inNormal, tooBig, zeroExp;
  assign inNormal = bexp > LONG_EXP_W'(SHORT_EXP_OFFSET);
  assign tooBig   = bexp > LONG_EXP_W'(LONG_EXP_TOP);
  assign zeroExp  = bexp == '0;

  // normal range: straight field extraction
  logic [SHORT_EXP_W-1:0] normExp;
  logic [SHORT_MAN_W-1:0] normMan;
  logic                   normGuard, normSticky;
  assign normExp    = SHORT_EXP_W'(bexp - LONG_EXP_W'(SHORT_EXP_OFFSET));
  assign normMan    = frac[LONG_FRAC_W-1 -: SHORT_MAN_W];
  assign normGuard  = frac[FRAC_DROP-1];
  assign normSticky = |frac[FRAC_DROP-2:0];

  // subnormal range: right shift of the full significand
  logic [SIG_W-1:0]        sig;
  logic [LONG_EXP_W:0]     shRaw;
  logic [SHIFT_W-1:0]      shAmt;
  logic [WIN_W-1:0]        win;
  logic [SHORT_MAN_W-1:0]  denMan;
  logic                    denGuard, denSticky;
  assign sig   = {1'b1, frac};
  assign shRaw = (LONG_EXP_W+1)'(DENORM_SHIFT_BASE) - {1'b0, bexp};
  assign shAmt = (shRaw > (LONG_EXP_W+1)'(SHIFT_CLAMP)) ? SHIFT_W'(SHIFT_CLAMP)
                                                        : SHIFT_W'(shRaw);
  assign win       = WIN_W'({sig, {(SIG_W+1){1'b0}}} >> shAmt);
  assign denMan    = win[WIN_W-1 -: SHORT_MAN_W];
  assign denGuard  = win[SIG_W];
  assign denSticky = |win[SIG_W-1:0];

  logic [SHORT_MAG_W-1:0] preMag;
  logic                   guardBit, stickyBits, roundUp;
  logic [SHORT_MAG_W:0]   magSum;

  always_comb begin
    if (inNormal) begin
      preMag     = {normExp, normMan};
      guardBit   = normGuard;
      stickyBits = normSticky;
    end else begin
      preMag     = {{SHORT_EXP_W{1'b0}}, denMan};
      guardBit   = denGuard;
      stickyBits = denSticky;
    end
    roundUp = guardBit & (stickyBits | preMag[0]);
    magSum  = {1'b0, preMag} + (SHORT_MAG_W+1)'(roundUp);
  end

  always_comb begin
    ovfOut  = 1'b0;
    unfOut  = 1'b0;
    dstWord = {sgn, magSum[SHORT_MAG_W-1:0]};
    if (zeroExp) begin
      dstWord = {sgn, {SHORT_MAG_W{1'b0}}};
      unfOut  = |frac;
    end else if (tooBig || magSum[SHORT_MAG_W]) begin
      dstWord = {sgn, {SHORT_MAG_W{1'b1}}};
      ovfOut  = 1'b1;
    end else if (magSum == '0) begin
      unfOut  = 1'b1;
    end
  end
endmodule

// File: rtl/sfcUnpackCore.sv
module sfcUnpackCore
  import sfcPkg::*;
(
  input  logic [SHORT_W-1:0] srcWord,
  output logic [LONG_W-1:0]  dstWord
);
  logic                   sgn;
  logic [SHORT_EXP_W-1:0] sexp;
  logic [SHORT_MAN_W-1:0] sman;
  assign {sgn, sexp, sman} = srcWord;

  logic [LEAD_W-1:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < SHORT_MAN_W; i++)
      if (sman[i]) lead = LEAD_W'(i);
  end

  logic [ALIGN_SH_W-1:0]  alignSh;
  logic [LONG_FRAC_W-1:0] denFrac;
  logic [LONG_EXP_W-1:0]  denExp, normExp;
  assign alignSh = ALIGN_SH_W'(LONG_FRAC_W) - ALIGN_SH_W'(lead);
  // the leading one is shifted out of the kept fraction bits
  assign denFrac = LONG_FRAC_W'({{(SIG_W-SHORT_MAN_W){1'b0}}, sman} << alignSh);
  assign denExp  = LONG_EXP_W'(lead) + LONG_EXP_W'(DENORM_EXP_BASE);
  assign normExp = LONG_EXP_W'(sexp) + LONG_EXP_W'(SHORT_EXP_OFFSET);

  always_comb begin
    if (sexp != '0)
      dstWord = {sgn, normExp, sman, {FRAC_DROP{1'b0}}};
    else if (sman != '0)
      dstWord = {sgn, denExp, denFrac};
    else
      dstWord = {sgn, {(LONG_W-1){1'b0}}};
  end
endmodule

// File: rtl/sfcCtrl.sv
module sfcCtrl
  import sfcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       modeUnpack,
  output sfcStrobe_t strobe,
  output logic       outValid
);
  assign strobe.loadOut   = inValid;
  assign strobe.selUnpack = modeUnpack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/sfcDatapath.sv
module sfcDatapath
  import sfcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sfcStrobe_t        strobe,
  input  logic [LONG_W-1:0] inWord,
  output logic [LONG_W-1:0] outWord,
  output logic              ovfFlag,
  output logic              unfFlag
);
  logic [SHORT_W-1:0] packWord;
  logic [LONG_W-1:0]  unpackWord;
  logic               packOvf, packUnf;

  sfcPackCore u_pack (
    .srcWord (inWord),
    .dstWord (packWord),
    .ovfOut  (packOvf),
    .unfOut  (packUnf)
  );

  sfcUnpackCore u_unpack (
    .srcWord (inWord[SHORT_W-1:0]),
    .dstWord (unpackWord)
  );

  logic [LONG_W-1:0] nextWord;
  logic              nextOvf, nextUnf;
  always_comb begin
    if (strobe.selUnpack) begin
      nextWord = unpackWord;
      nextOvf  = 1'b0;
      nextUnf  = 1'b0;
    end else begin
      nextWord = {{(LONG_W-SHORT_W){1'b0}}, packWord};
      nextOvf  = packOvf;
      nextUnf  = packUnf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (strobe.loadOut) begin
      outWord <= nextWord;
      ovfFlag <= nextOvf;
      unfFlag <= nextUnf;
    end
  end
endmodule

// File: rtl/shortFloatConv.sv
module shortFloatConv
  import sfcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              modeUnpack,
  input  logic [LONG_W-1:0] inWord,
  output logic              outValid,
  output logic [LONG_W-1:0] outWord,
  output logic              ovfFlag,
  output logic              unfFlag
);
  sfcStrobe_t strobe;

  sfcCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .modeUnpack (modeUnpack),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  sfcDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inWord  (inWord),
    .outWord (outWord),
    .ovfFlag (ovfFlag),
    .unfFlag (unfFlag)
  );
endmodule

// File: rtl/shortFloatConv_chk.sv
module shortFloatConv_chk
  import sfcPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              modeUnpack,
  input logic [LONG_W-1:0] inWord,
  input logic              outValid,
  input logic [LONG_W-1:0] outWord,
  input logic              ovfFlag,
  input logic              unfFlag
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R2
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outWord) && $stable(ovfFlag) && $stable(unfFlag)));
  // R3
  pack_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !modeUnpack) |=> (outWord[LONG_W-1:SHORT_W] == '0));
  // R6
  ovf_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> (outWord[SHORT_MAG_W-1:0] == {SHORT_MAG_W{1'b1}}));
  // R7
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> (outWord[SHORT_MAG_W-1:0] == '0));
  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && unfFlag));
  // R9
  unpack_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeUnpack && inWord[SHORT_MAG_W-1:0] == '0)
      |=> (outWord[LONG_W-2:0] == '0));
  // R10
  unpack_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeUnpack) |=> (!ovfFlag && !unfFlag));
endmodule

bind shortFloatConv shortFloatConv_chk u_chk (.*);

// File: tb/shortFloatConv_tb.sv
`timescale 1ns/1ps
module shortFloatConv_tb;
  localparam int NV = 26;
  // {req[3:0], mode, in[31:0], expected[31:0], ovf, unf}
  localparam logic [70:0] VEC [NV] = '{
    {4'd3,  1'b0, 32'h3F800000, 32'h00003800, 1'b0, 1'b0}, // R3 one
    {4'd3,  1'b0, 32'hC0200000, 32'h0000C200, 1'b0, 1'b0}, // R3 negative
    {4'd3,  1'b0, 32'h3F800800, 32'h00003800, 1'b0, 1'b0}, // R3 tie, even stays
    {4'd3,  1'b0, 32'h3F801800, 32'h00003802, 1'b0, 1'b0}, // R3 tie, odd rounds up
    {4'd3,  1'b0, 32'h3F800801, 32'h00003801, 1'b0, 1'b0}, // R3 above half
    {4'd4,  1'b0, 32'h3FFFFFFF, 32'h00004000, 1'b0, 1'b0}, // R4 carry to exponent
    {4'd3,  1'b0, 32'h43FFF000, 32'h00007FFF, 1'b0, 1'b0}, // R3 largest exact
    {4'd6,  1'b0, 32'h43FFF800, 32'h00007FFF, 1'b1, 1'b0}, // R6 overflow by rounding
    {4'd6,  1'b0, 32'hC4000000, 32'h0000FFFF, 1'b1, 1'b0}, // R6 exponent too big
    {4'd6,  1'b0, 32'h7F800000, 32'h00007FFF, 1'b1, 1'b0}, // R6 infinity
    {4'd5,  1'b0, 32'h3C000000, 32'h00000400, 1'b0, 1'b0}, // R5 top subnormal
    {4'd5,  1'b0, 32'h37000000, 32'h00000001, 1'b0, 1'b0}, // R5 smallest
    {4'd7,  1'b0, 32'h36800000, 32'h00000000, 1'b0, 1'b1}, // R7 tie to zero
    {4'd5,  1'b0, 32'h36800001, 32'h00000001, 1'b0, 1'b0}, // R5 just above tie
    {4'd7,  1'b0, 32'h80000001, 32'h00008000, 1'b0, 1'b1}, // R7 tiny negative
    {4'd7,  1'b0, 32'h80000000, 32'h00008000, 1'b0, 1'b0}, // R7 exact zero
    {4'd5,  1'b0, 32'h3C7FFFFF, 32'h00000800, 1'b0, 1'b0}, // R5 promote to normal
    {4'd8,  1'b1, 32'h00003800, 32'h3F800000, 1'b0, 1'b0}, // R8
    {4'd8,  1'b1, 32'h0000C200, 32'hC0200000, 1'b0, 1'b0}, // R8
    {4'd8,  1'b1, 32'h00007FFF, 32'h43FFF000, 1'b0, 1'b0}, // R8 largest
    {4'd9,  1'b1, 32'h00000001, 32'h37000000, 1'b0, 1'b0}, // R9 smallest
    {4'd9,  1'b1, 32'h00000400, 32'h3C000000, 1'b0, 1'b0}, // R9
    {4'd9,  1'b1, 32'h00008003, 32'hB7C00000, 1'b0, 1'b0}, // R9 shifted tail
    {4'd9,  1'b1, 32'h00008000, 32'h80000000, 1'b0, 1'b0}, // R9 signed zero
    {4'd8,  1'b1, 32'h00000800, 32'h3C800000, 1'b0, 1'b0}, // R8 smallest normal
    {4'd8,  1'b1, 32'hABCD3800, 32'h3F800000, 1'b0, 1'b0}  // R8 upper half ignored
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        modeUnpack = 1'b0;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic [31:0] outWord;
  logic        ovfFlag, unfFlag;
  int          checkCount = 0;
  int          failCount = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  shortFloatConv u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeUnpack(modeUnpack),
    .inWord(inWord), .outValid(outValid), .outWord(outWord),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checkCount++;
    if (act !== expv) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outValid", {31'b0, outValid}, 32'd0);
    check("R1 reset outWord", outWord, 32'd0);
    check("R1 reset flags", {30'b0, ovfFlag, unfFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle outValid", {31'b0, outValid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      inValid    = 1'b1;
      modeUnpack = VEC[i][66];
      inWord     = VEC[i][65:34];
      @(posedge clk);
      #2;
      check($sformatf("R%0d vec%0d word", VEC[i][70:67], i), outWord, VEC[i][33:2]);
      check($sformatf("R%0d vec%0d flags", VEC[i][70:67], i),
            {30'b0, ovfFlag, unfFlag}, {30'b0, VEC[i][1:0]});
      check($sformatf("R1 vec%0d outValid", i), {31'b0, outValid}, 32'd1);
    end

    // R2: idle cycles with changing inputs leave results alone
    held = outWord;
    @(negedge clk);
    inValid    = 1'b0;
    modeUnpack = 1'b0;
    inWord     = 32'h7F800000;
    @(negedge clk);
    inWord     = 32'h80000001;
    @(negedge clk);
    check("R1 drop outValid", {31'b0, outValid}, 32'd0);
    check("R2 hold word", outWord, held);
    check("R2 hold flags", {30'b0, ovfFlag, unfFlag}, 32'd0);

    // R6 then R10: overflow flag cleared by a following unpack
    @(negedge clk);
    inValid = 1'b1; modeUnpack = 1'b0; inWord = 32'h7F800000;
    @(negedge clk);
    check("R6 flag set", {30'b0, ovfFlag, unfFlag}, 32'd2);
    modeUnpack = 1'b1; inWord = 32'h00003800;
    @(negedge clk);
    check("R10 flag cleared", {30'b0, ovfFlag, unfFlag}, 32'd0);
    check("R8 after pack", outWord, 32'h3F800000);
    inValid = 1'b0;

    // R1 reset mid-stream clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset again", outWord, 32'd0);
    rstN = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule